// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block collects a vector of level-sensitive interrupt sources and delivers each one to a set of processor cores. Every source carries a global enable and a per-source control word whose low bits pick the target cores. Every core has its own bank of mask bits. When a core reads its acknowledge register, it gets the number of the lowest-numbered source that is asserted, enabled, routed to it and not masked by it. If no such source exists, the read returns 1023.

Software reaches the block through a simple register bus. A core-ID input travels with each access and selects which core's private bank is used. Enable and mask bits are never written as bitmaps. Instead, software writes a source number to a set register or to a clear register. Source 0 and source 1 are summary lines that a doorbell unit drives, and sources 2 and above are peripherals. Source 5 is a per-core local timer: only the per-core mask gates it.

Top module: `ic_route_ctrl`

## Requirements
- R1: After reset, every source is globally disabled, every mask bit of every core is set, and every source control word is zero. An acknowledge read therefore returns 1023 and `cpu_irq` is all zero.
- R2: Writing source number N to global offset 0x030 enables source N, and writing N to 0x034 disables it. A disabled source is never acknowledged, with the exception given in R7.
- R3: Writing N to per-core offset 0x2048 masks source N for the core named on `bus_cpu` only, and writing N to 0x204C unmasks it for that core only.
- R4: A read of global offset 0x000 returns the number of implemented sources in bits [11:2] and zero in all other bits.
- R5: The source control word at 0x100 + 4*N holds all 32 written bits and reads them back unchanged. Bit c of this word (c below the core count) routes source N to core c.
- R6: A read of per-core offset 0x2044 returns, in bits [9:0], the lowest-numbered source that is asserted, enabled, routed to the reading core and unmasked for it, or 1023 if there is none. Repeating the read returns the same value, because the read changes no state.
- R7: Source 5 ignores both its global enable and its routing bits. It reaches a core whenever it is asserted and unmasked for that core.
- R8: `cpu_irq[c]` is high exactly when an acknowledge read by core c would return a value other than 1023.
- R9: An index write (set/clear enable, mask, unmask) whose value is not below the number of sources changes no state.
- R10: A read request is answered one cycle later with `bus_rvalid` high. A write request, or no request, leaves `bus_rvalid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_level | input | NUM_SRC | Level of each interrupt source, bit N is source N |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Core issuing the access, selects the per-core bank |
| bus_addr | input | 14 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data returned, one cycle after the read request |
| cpu_irq | output | NUM_CPU | Interrupt request line to each core |

## Verification
The hardest cases to reach are the ones where the stored index gets truncated. An index write at or above the source count would alias onto a low source if the index were cut to its low bits. The stimulus writes 35 and 39, which alias onto sources 3 and 7, and then uses the acknowledge read to show that those sources kept their masked or disabled state. A second hard case is the local timer, which is disabled and routed nowhere. The bench drives that source, unmasks it for one core only, and checks that exactly that core acknowledges it while the other core sees nothing.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 14;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] ID_NONE = 10'h3FF;

  localparam logic [ADDR_W-1:0] A_CTRL = 14'h0000;
  localparam logic [ADDR_W-1:0] A_EN_SET = 14'h0030;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 14'h0034;
  localparam logic [ADDR_W-1:0] A_SCTL_BASE = 14'h0100;
  localparam logic [ADDR_W-1:0] A_ACK = 14'h2044;
  localparam logic [ADDR_W-1:0] A_MSK_SET = 14'h2048;
  localparam logic [ADDR_W-1:0] A_MSK_CLR = 14'h204C;
endpackage

// File: rtl/ic_cfg_regs.sv
module ic_cfg_regs
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  localparam int SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en_set,
  input  logic                             en_clr,
  input  logic                             msk_set,
  input  logic                             msk_clr,
  input  logic [SIDX_W-1:0]                idx,
  input  logic [CPU_W-1:0]                 cpu,
  input  logic                             sctl_we,
  input  logic [SIDX_W-1:0]                sctl_idx,
  input  logic [DATA_W-1:0]                sctl_wdata,
  output logic [NUM_SRC-1:0]               enable,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask,
  output logic [NUM_SRC-1:0][DATA_W-1:0]   sctl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      mask   <= '1;
      sctl   <= '0;
    end else begin
      if (en_set) enable[idx] <= 1'b1;
      if (en_clr) enable[idx] <= 1'b0;
      if (msk_set) mask[cpu][idx] <= 1'b1;
      if (msk_clr) mask[cpu][idx] <= 1'b0;
      if (sctl_we) sctl[sctl_idx] <= sctl_wdata;
    end
  end
endmodule

// File: rtl/ic_pick.sv
module ic_pick
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               found,
  output logic [ID_W-1:0]    id
);
  always_comb begin
    found = 1'b0;
    id    = ID_NONE;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (req[n]) begin
        found = 1'b1;
        id    = ID_W'(n);
      end
    end
  end
endmodule

// File: rtl/ic_route_ctrl.sv
module ic_route_ctrl
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int LOCAL_ID = 5,
  localparam int SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int SCTL_END = 256 + 4 * NUM_SRC;
  localparam logic [DATA_W-1:0] NSRC_WORD = DATA_W'(NUM_SRC);

  logic wr, rd, idx_ok, sctl_hit;
  logic [SIDX_W-1:0] sctl_idx;
  logic [ADDR_W-1:0] sctl_off;
  logic [NUM_SRC-1:0] enable;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0][DATA_W-1:0] sctl;
  logic [NUM_CPU-1:0][ID_W-1:0] ack_id;
  logic [DATA_W-1:0] rd_mux;

  assign wr = bus_req & bus_we;
  assign rd = bus_req & ~bus_we;
  assign idx_ok = bus_wdata < NSRC_WORD;
  assign sctl_off = bus_addr - A_SCTL_BASE;
  assign sctl_idx = sctl_off[SIDX_W+1:2];
  assign sctl_hit = (int'(bus_addr) >= 256) && (int'(bus_addr) < SCTL_END)
                    && (bus_addr[1:0] == 2'b00);

  ic_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .en_set    (wr && idx_ok && bus_addr == A_EN_SET),
    .en_clr    (wr && idx_ok && bus_addr == A_EN_CLR),
    .msk_set   (wr && idx_ok && bus_addr == A_MSK_SET),
    .msk_clr   (wr && idx_ok && bus_addr == A_MSK_CLR),
    .idx       (bus_wdata[SIDX_W-1:0]),
    .cpu       (bus_cpu),
    .sctl_we   (wr && sctl_hit),
    .sctl_idx  (sctl_idx),
    .sctl_wdata(bus_wdata),
    .enable    (enable),
    .mask      (mask),
    .sctl      (sctl)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] elig;
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (n == LOCAL_ID) begin : g_local
        assign elig[n] = src_level[n] & ~mask[c][n];
      end else begin : g_global
        assign elig[n] = src_level[n] & ~mask[c][n] & enable[n] & sctl[n][c];
      end
    end
    ic_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .req  (elig),
      .found(cpu_irq[c]),
      .id   (ack_id[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CTRL) rd_mux[11:2] = NSRC_WORD[9:0];
    else if (bus_addr == A_ACK) rd_mux[ID_W-1:0] = ack_id[bus_cpu];
    else if (sctl_hit) rd_mux = sctl[sctl_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ic_route_ctrl_chk.sv
module ic_route_ctrl_chk
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_level,
  input logic               bus_req,
  input logic               bus_we,
  input logic [CPU_W-1:0]   bus_cpu,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_CPU-1:0] cpu_irq
);
  logic ack_rd, ctrl_rd, irq_sel;
  assign ack_rd  = bus_req && !bus_we && bus_addr == A_ACK;
  assign ctrl_rd = bus_req && !bus_we && bus_addr == A_CTRL;
  assign irq_sel = cpu_irq[bus_cpu];

  assert_rd_resp_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);
  assert_no_resp_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> !bus_rvalid);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cpu_irq == '0);
  assert_ctrl_count_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> bus_rdata[11:2] == NUM_SRC[9:0]);
  assert_idle_none_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !irq_sel) |=> bus_rdata[ID_W-1:0] == ID_NONE);
  assert_busy_some_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && irq_sel) |=> bus_rdata[ID_W-1:0] != ID_NONE);
  assert_ack_live_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(ack_rd) && int'(bus_rdata[ID_W-1:0]) < NUM_SRC)
      |-> (($past(src_level) >> bus_rdata[ID_W-1:0]) & 1) != 0);
endmodule

bind ic_route_ctrl ic_route_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_level (src_level),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_cpu   (bus_cpu),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .cpu_irq   (cpu_irq)
);

// File: tb/sim_ic_route_ctrl.sv
module sim_ic_route_ctrl;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] src_level = '0;
  logic bus_req = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_cpu = '0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NC-1:0] cpu_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ic_route_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC), .LOCAL_ID(5)) u0 (
    .clk(clk), .rst(rst), .src_level(src_level), .bus_req(bus_req),
    .bus_we(bus_we), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cpu_irq(cpu_irq)
  );

  // row: req[123:120] op[119:118] cpu[117:116] addr[115:100] wdata[99:68] src[67:36] exp[35:4] pad[3:0]
  // op 0 = write, 1 = read and compare
  localparam logic [123:0] TAB [0:NV-1] = '{
    {4'd1, 2'd1, 2'd0, 16'h2044, 32'h0, 32'hFFFFFFFF, 32'h3FF, 4'h0},      // R1
    {4'd4, 2'd1, 2'd0, 16'h0000, 32'h0, 32'h0, 32'h80, 4'h0},              // R4
    {4'd5, 2'd0, 2'd0, 16'h011C, 32'hABCD0001, 32'h0, 32'h0, 4'h0},
    {4'd5, 2'd1, 2'd0, 16'h011C, 32'h0, 32'h0, 32'hABCD0001, 4'h0},        // R5
    {4'd2, 2'd0, 2'd0, 16'h0030, 32'd7, 32'h0, 32'h0, 4'h0},
    {4'd3, 2'd0, 2'd0, 16'h204C, 32'd7, 32'h0, 32'h0, 4'h0},
    {4'd6, 2'd1, 2'd0, 16'h2044, 32'h0, 32'h80, 32'd7, 4'h0},              // R6
    {4'd3, 2'd1, 2'd1, 16'h2044, 32'h0, 32'h80, 32'h3FF, 4'h0},            // R3
    {4'd5, 2'd0, 2'd0, 16'h010C, 32'h3, 32'h0, 32'h0, 4'h0},
    {4'd2, 2'd0, 2'd0, 16'h0030, 32'd3, 32'h0, 32'h0, 4'h0},
    {4'd3, 2'd0, 2'd0, 16'h204C, 32'd3, 32'h0, 32'h0, 4'h0},
    {4'd6, 2'd1, 2'd0, 16'h2044, 32'h0, 32'h88, 32'd3, 4'h0},              // R6 lowest wins
    {4'd6, 2'd1, 2'd0, 16'h2044, 32'h0, 32'h88, 32'd3, 4'h0},              // R6 no side effect
    {4'd3, 2'd0, 2'd0, 16'h2048, 32'd3, 32'h0, 32'h0, 4'h0},
    {4'd3, 2'd1, 2'd0, 16'h2044, 32'h0, 32'h88, 32'd7, 4'h0},              // R3
    {4'd2, 2'd0, 2'd0, 16'h0034, 32'd7, 32'h0, 32'h0, 4'h0},
    {4'd2, 2'd1, 2'd0, 16'h2044, 32'h0, 32'h88, 32'h3FF, 4'h0},            // R2
    {4'd7, 2'd0, 2'd1, 16'h204C, 32'd5, 32'h0, 32'h0, 4'h0},
    {4'd7, 2'd1, 2'd1, 16'h2044, 32'h0, 32'h20, 32'd5, 4'h0},              // R7
    {4'd7, 2'd1, 2'd0, 16'h2044, 32'h0, 32'h20, 32'h3FF, 4'h0},            // R7
    {4'd9, 2'd0, 2'd0, 16'h204C, 32'd35, 32'h0, 32'h0, 4'h0},
    {4'd9, 2'd1, 2'd0, 16'h2044, 32'h0, 32'h08, 32'h3FF, 4'h0},            // R9
    {4'd9, 2'd0, 2'd0, 16'h0030, 32'd39, 32'h0, 32'h0, 4'h0},
    {4'd9, 2'd1, 2'd0, 16'h2044, 32'h0, 32'h80, 32'h3FF, 4'h0}             // R9
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic access(input bit we, input logic [1:0] cpu, input logic [13:0] addr,
                        input logic [31:0] wd, output logic [31:0] rdv, output logic rv);
    @(negedge clk);
    bus_req = 1'b1;
    bus_we = we;
    bus_cpu = cpu;
    bus_addr = addr;
    bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0;
    bus_we = 1'b0;
    rdv = bus_rdata;
    rv = bus_rvalid;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rdv;
    logic rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, {28'h0, cpu_irq}, 32'h0);        // R1 no request after reset
    check(10, {31'h0, bus_rvalid}, 32'h0);    // R10 idle

    for (int i = 0; i < NV; i++) begin
      src_level = TAB[i][67:36];
      access(TAB[i][119:118] == 2'd0, TAB[i][117:116], TAB[i][113:100],
             TAB[i][99:68], rdv, rv);
      if (TAB[i][119:118] == 2'd1) check(int'(TAB[i][123:120]), rdv, TAB[i][35:4]);
    end

    // R8: source 5 unmasked only on core 1
    src_level = 32'h20;
    @(negedge clk);
    check(8, {28'h0, cpu_irq}, 32'h2);
    src_level = 32'h0;
    @(negedge clk);
    check(8, {28'h0, cpu_irq}, 32'h0);

    // R10: write gives no response, read does
    access(1'b1, 2'd0, 14'h0030, 32'd2, rdv, rv);
    check(10, {31'h0, rv}, 32'h0);
    access(1'b0, 2'd0, 14'h0000, 32'd0, rdv, rv);
    check(10, {31'h0, rv}, 32'h1);

    // R1: reset in mid-run restores masks and control words
    src_level = 32'h20;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(1, {28'h0, cpu_irq}, 32'h0);
    access(1'b0, 2'd1, 14'h2044, 32'd0, rdv, rv);
    check(1, rdv, 32'h3FF);
    access(1'b0, 2'd0, 14'h011C, 32'd0, rdv, rv);
    check(1, rdv, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule